// File: doc/BRIEF.md
# DRAM Power-Up and Periodic Refresh Scheduler

This block controls the row and column strobes of an asynchronous 2M x 8 dynamic RAM during two phases. After reset it keeps all strobes inactive for a start-up wait and then runs a burst of initialization refresh cycles. When that burst is over it raises a ready flag, and from then on it issues one refresh at a fixed interval. The interval is chosen so that all 2048 rows are refreshed within the 32 ms retention period, which works out to about one refresh every 15.6 us.

Each refresh lowers the column strobe before the row strobe, so the DRAM's own internal row counter picks the row. No address is driven. The write-enable strobe stays high throughout, which keeps the part out of its test mode. The block shares the strobe pins with an access controller through a request/grant handshake. It drives the pins only while it holds the grant, and it keeps its request raised until the row precharge of its cycle has ended.

Refresh credits that arrive while the grant is withheld, for example during a long page access, are stored up to a small limit and then issued one after another. All delays are counted in cycles of the block clock. They are derived from a clock frequency parameter together with nanosecond and microsecond minimum figures.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, and on leaving it, `ras_n`, `cas_n` and `we_n` are high and `rf_req`, `rf_own` and `init_done` are low.
- R2: `rf_req` stays low for the first STARTUP_CYC rising edges after reset is released (STARTUP_US times CLK_MHZ, 100 in the bench) and is high right after edge STARTUP_CYC.
- R3: Exactly INIT_CYCLES refresh cycles (8) are completed before `init_done` rises. `init_done` rises at the edge that ends the precharge of the last of them and stays high until reset.
- R4: In each refresh `cas_n` falls CSR_CYC cycles (1) before `ras_n` falls, stays low for CHR_CYC cycles (1) after `ras_n` falls, and returns high while `ras_n` is still low.
- R5: `we_n` is high in every cycle, so no refresh can start the DRAM's test mode.
- R6: `ras_n` stays low for exactly RAS_CYC cycles, the larger of CHR_CYC+1 and ceil(50 ns x f). Precharge then lasts RP_CYC cycles, the larger of ceil(30 ns x f) and ceil(84 ns x f) minus RAS_CYC. In the bench this gives 3 and 2.
- R7: `rf_req` stays high until `rf_gnt` is sampled high. The refresh cycle begins in the next cycle. `rf_req` stays high through the end of precharge and is then low for at least one cycle.
- R8: Once `init_done` is high, a refresh credit is generated every REFI_CYC cycles, where REFI_CYC is floor(REFRESH_MS x 1000 x CLK_MHZ / ROWS) (200 in the bench). With the grant given at once, successive rises of `rf_req` are REFI_CYC cycles apart.
- R9: While the grant is withheld, credits accumulate up to PEND_MAX (3 in the bench) and any further credits are dropped. Once the grant is given, every stored credit is issued back to back.
- R10: `rf_own` is high exactly for the CSR_CYC+RAS_CYC+RP_CYC cycles of a refresh. Whenever it is low, `ras_n` and `cas_n` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, frequency set by CLK_MHZ |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_gnt | input | 1 | Grant of the strobe pins from the access arbiter |
| rf_req | output | 1 | Request for the strobe pins, held through precharge |
| rf_own | output | 1 | High while this block drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Ready for normal access after the initialization burst |

## Verification
Every output is decoded from registered state, so each result shows in the cycle after the edge that causes it. `rf_req` rises one edge after the start-up count ends or after a credit is registered. The strobes start one edge after a grant is sampled. A credit is registered REFI_CYC edges after the timer starts, and the request follows one edge later. The bench's reference model advances on the same rising edge from the same sampled grant. It compares all outputs at the next falling edge, so every expected value is read exactly one register stage after its cause. Directed measurements of start-up delay, initialization count, request spacing and backlog size sample at the same point.

// File: rtl/dram_rf_pkg.sv
// Shared types and helpers for the DRAM refresh scheduler.
// Assumes integer arithmetic is wide enough for ns x MHz products.
package dram_rf_pkg;

    typedef enum logic [2:0] {
        SQ_START,   // power-up wait, strobes idle
        SQ_IDLE,    // nothing outstanding this cycle
        SQ_REQ,     // request raised, waiting for grant
        SQ_CSR,     // column strobe low ahead of row strobe
        SQ_RAS,     // row strobe low
        SQ_PRE      // row precharge, request still held
    } sq_state_t;

    // Whole cycles needed to cover a time in ns at a clock in MHz.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rf_interval_timer.sv
// Free-running interval timer: pulses tick once every PERIOD cycles
// while en is high. Assumes PERIOD >= 2; holds at zero while en is low.
module rf_interval_timer #(
    parameter int PERIOD = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(PERIOD);

    logic [TW-1:0] cnt;

    // Count cycles and wrap at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == TW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == TW'(PERIOD - 1));
endmodule

// File: rtl/rf_credit_counter.sv
// Saturating store of refresh credits. Adds one on inc and removes one
// on dec. Both in the same cycle leave it unchanged. Assumes dec is
// only raised while at least one credit is stored.
module rf_credit_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic avail
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] credits;

    // Update the stored credit count, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credits <= '0;
        end else if (inc && !dec && credits != CW'(LIMIT)) begin
            credits <= credits + 1'b1;
        end else if (dec && !inc && credits != '0) begin
            credits <= credits - 1'b1;
        end
    end

    assign avail = (credits != '0);
endmodule

// File: rtl/rf_cbr_sequencer.sv
// Strobe sequencer: power-up wait, initialization burst, then one
// column-before-row refresh per available credit, each under the grant.
// Assumes INIT_N >= 1, CSR_CYC >= 1 and CHR_CYC < RAS_CYC.
module rf_cbr_sequencer
    import dram_rf_pkg::*;
#(
    parameter int STARTUP_CYC = 10000,
    parameter int INIT_N      = 8,
    parameter int CSR_CYC     = 1,
    parameter int CHR_CYC     = 1,
    parameter int RAS_CYC     = 3,
    parameter int RP_CYC      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic credit_avail,
    input  logic gnt,
    output logic req,
    output logic own,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done,
    output logic credit_take
);
    localparam int MAXV = max2(max2(STARTUP_CYC, RAS_CYC), max2(RP_CYC, CSR_CYC));
    localparam int CW   = $clog2(MAXV + 1);
    localparam int IW   = $clog2(INIT_N + 1);

    sq_state_t       state;
    logic [CW-1:0]   cnt;
    logic [IW-1:0]   init_left;
    logic            pre_last;

    assign pre_last = (state == SQ_PRE) && (cnt == CW'(RP_CYC - 1));

    // Advance through the phases and count down the initialization burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_START;
            cnt       <= '0;
            init_left <= IW'(INIT_N);
            init_done <= 1'b0;
        end else begin
            case (state)
                SQ_START: begin
                    if (cnt == CW'(STARTUP_CYC - 1)) begin
                        state <= SQ_REQ;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_IDLE: begin
                    if (init_left != '0 || credit_avail) state <= SQ_REQ;
                end
                SQ_REQ: begin
                    if (gnt) begin
                        state <= SQ_CSR;
                        cnt   <= '0;
                    end
                end
                SQ_CSR: begin
                    if (cnt == CW'(CSR_CYC - 1)) begin
                        state <= SQ_RAS;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_RAS: begin
                    if (cnt == CW'(RAS_CYC - 1)) begin
                        state <= SQ_PRE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_PRE: begin
                    if (pre_last) begin
                        state <= SQ_IDLE;
                        cnt   <= '0;
                        if (init_left != '0) begin
                            init_left <= init_left - 1'b1;
                            if (init_left == IW'(1)) init_done <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SQ_START;
            endcase
        end
    end

    // Decode the strobes and handshake from the current phase.
    always_comb begin
        own         = (state == SQ_CSR) || (state == SQ_RAS) || (state == SQ_PRE);
        req         = own || (state == SQ_REQ);
        ras_n       = !(state == SQ_RAS);
        cas_n       = !((state == SQ_CSR) ||
                        ((state == SQ_RAS) && (cnt < CW'(CHR_CYC))));
        we_n        = 1'b1;
        credit_take = pre_last && (init_left == '0);
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// Top of the refresh scheduler. Converts timing figures into cycle
// counts at CLK_MHZ and joins the interval timer, the credit store and
// the strobe sequencer. Assumes the arbiter keeps rf_gnt while rf_req is high.
module dram_refresh_sched
    import dram_rf_pkg::*;
#(
    parameter int CLK_MHZ     = 50,
    parameter int STARTUP_US  = 200,
    parameter int REFRESH_MS  = 32,
    parameter int ROWS        = 2048,
    parameter int INIT_CYCLES = 8,
    parameter int CSR_CYC     = 1,
    parameter int CHR_CYC     = 1,
    parameter int RAS_MIN_NS  = 50,
    parameter int RP_MIN_NS   = 30,
    parameter int RC_MIN_NS   = 84,
    parameter int PEND_MAX    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rf_gnt,
    output logic rf_req,
    output logic rf_own,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done
);
    localparam int STARTUP_CYC = STARTUP_US * CLK_MHZ;
    localparam int REFI_CYC    = (REFRESH_MS * 1000 * CLK_MHZ) / ROWS;
    localparam int RAS_CYC     = max2(CHR_CYC + 1, ns_to_cyc(RAS_MIN_NS, CLK_MHZ));
    localparam int RP_CYC      = max2(ns_to_cyc(RP_MIN_NS, CLK_MHZ),
                                      ns_to_cyc(RC_MIN_NS, CLK_MHZ) - RAS_CYC);

    logic tick;
    logic credit_avail;
    logic credit_take;

    rf_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .tick  (tick)
    );

    rf_credit_counter #(.LIMIT(PEND_MAX)) u_credits (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (credit_take),
        .avail (credit_avail)
    );

    rf_cbr_sequencer #(
        .STARTUP_CYC (STARTUP_CYC),
        .INIT_N      (INIT_CYCLES),
        .CSR_CYC     (CSR_CYC),
        .CHR_CYC     (CHR_CYC),
        .RAS_CYC     (RAS_CYC),
        .RP_CYC      (RP_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .credit_avail (credit_avail),
        .gnt          (rf_gnt),
        .req          (rf_req),
        .own          (rf_own),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .init_done    (init_done),
        .credit_take  (credit_take)
    );
endmodule

// File: rtl/dram_refresh_sched_chk.sv
// Protocol checker for the refresh scheduler, attached by bind.
// Watches only the top-level ports; assumes RAS_CYC matches the top.
module dram_refresh_sched_chk #(
    parameter int RAS_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic rf_gnt,
    input logic rf_req,
    input logic rf_own,
    input logic ras_n,
    input logic cas_n,
    input logic init_done
);
    logic [15:0] ras_lo_cnt;

    // Measure how long the row strobe has been low.
    always_ff @(posedge clk) begin
        if (!rst_n)      ras_lo_cnt <= '0;
        else if (!ras_n) ras_lo_cnt <= ras_lo_cnt + 1'b1;
        else             ras_lo_cnt <= '0;
    end

    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    a_r4_cas_up_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $past(cas_n));

    a_r6_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_lo_cnt == 16'(RAS_CYC)));

    a_r10_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_own |-> (ras_n && cas_n));

    a_r7_own_under_req: assert property (@(posedge clk) disable iff (!rst_n)
        rf_own |-> rf_req);

    a_r7_start_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_own) |-> $past(rf_gnt));

    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.RAS_CYC(RAS_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rf_gnt    (rf_gnt),
    .rf_req    (rf_req),
    .rf_own    (rf_own),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .init_done (init_done)
);

// File: tb/dram_refresh_sched_bench.sv
// Bench: behavioural cycle model compared on every clock, plus directed
// measurements of start-up, init burst, refresh spacing and backlog.
module dram_refresh_sched_bench;
    // Expected figures worked out from the requirements at 50 MHz.
    localparam int STARTUP = 100;   // 2 us x 50
    localparam int REFI    = 200;   // 1 ms x 1000 x 50 / 250
    localparam int INIT_N  = 8;
    localparam int CSR     = 1;
    localparam int CHR     = 1;
    localparam int RASL    = 3;     // ceil(50 ns / 20 ns)
    localparam int RP      = 2;     // max(ceil(30/20), ceil(84/20) - 3)
    localparam int LEN     = CSR + RASL + RP;
    localparam int PMAX    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rf_gnt = 1'b0;
    logic rf_req, rf_own, ras_n, cas_n, we_n, init_done;

    always #10 clk = ~clk;

    dram_refresh_sched #(
        .CLK_MHZ(50), .STARTUP_US(2), .REFRESH_MS(1), .ROWS(250),
        .INIT_CYCLES(8), .PEND_MAX(3)
    ) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .rf_gnt(rf_gnt), .rf_req(rf_req),
        .rf_own(rf_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .init_done(init_done)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit hold   = 1'b0;
    bit started = 1'b0;
    bit done_run = 1'b0;

    // Reference model state: mode 0 start, 1 idle, 2 request, 3 refresh.
    int m_mode = 0, m_start = 0, m_init = INIT_N, m_pend = 0;
    int m_pos = 0, m_tmr = 0, m_ticks = 0;
    bit m_done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        bit tick, dec, nd;
        if (!rst_n) begin
            m_mode = 0; m_start = 0; m_init = INIT_N; m_pend = 0;
            m_pos = 0; m_tmr = 0; m_done = 1'b0;
        end else begin
            cyc++;
            tick = m_done && (m_tmr == REFI - 1);
            if (m_done) m_tmr = (m_tmr == REFI - 1) ? 0 : m_tmr + 1;
            dec = 1'b0;
            nd  = m_done;
            case (m_mode)
                0: begin m_start++; if (m_start == STARTUP) m_mode = 2; end
                1: if (m_init > 0 || m_pend > 0) m_mode = 2;
                2: if (rf_gnt) begin m_mode = 3; m_pos = 0; end
                default: begin
                    m_pos++;
                    if (m_pos == LEN) begin
                        m_mode = 1;
                        if (m_init > 0) begin
                            m_init--;
                            if (m_init == 0) nd = 1'b1;
                        end else dec = 1'b1;
                    end
                end
            endcase
            if (tick && !dec) m_pend = (m_pend < PMAX) ? m_pend + 1 : PMAX;
            else if (dec && !tick) m_pend--;
            m_done = nd;
            if (tick) m_ticks++;
        end
        started = 1'b1;
    end

    // Compare against the model at the falling edge, then drive the grant.
    always @(negedge clk) begin
        bit e_req, e_own, e_ras, e_cas;
        if (started && !done_run) begin
            e_req = (m_mode >= 2);
            e_own = (m_mode == 3);
            e_ras = !(m_mode == 3 && m_pos >= CSR && m_pos < CSR + RASL);
            e_cas = !(m_mode == 3 && m_pos < CSR + CHR);
            chk(rf_req == e_req, "R7", "rf_req", int'(rf_req), int'(e_req));
            chk(rf_own == e_own, "R10", "rf_own", int'(rf_own), int'(e_own));
            chk(ras_n == e_ras, "R6", "ras_n", int'(ras_n), int'(e_ras));
            chk(cas_n == e_cas, "R4", "cas_n", int'(cas_n), int'(e_cas));
            chk(we_n == 1'b1, "R5", "we_n", int'(we_n), 1);
            chk(init_done == m_done, "R3", "init_done", int'(init_done), int'(m_done));
        end
        rf_gnt = hold ? 1'b0 : rf_req;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        if (cyc > 20000 && !done_run) begin
            done_run = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<=%0d", cyc, 20000);
            report();
        end
    end

    int ras_falls;
    bit prev_ras = 1'b1;
    bit prev_req = 1'b0;
    int last_rise = -1;
    int gap = 0;

    // Count row strobe falls and request rises for the directed checks.
    always @(negedge clk) begin
        if (prev_ras && !ras_n) ras_falls++;
        if (!prev_req && rf_req) begin
            if (last_rise >= 0) gap = cyc - last_rise;
            last_rise = cyc;
        end
        prev_ras = ras_n;
        prev_req = rf_req;
    end

    initial begin
        int first_req = -1;
        int t0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ras_n && cas_n && we_n, "R1", "strobes in reset",
            int'({ras_n, cas_n, we_n}), 7);
        chk(!rf_req && !rf_own && !init_done, "R1", "req/own/ready in reset",
            int'({rf_req, rf_own, init_done}), 0);
        rst_n = 1'b1;
        ras_falls = 0;
        while (!rf_req) begin
            @(negedge clk);
            if (rf_req) first_req = cyc;
        end
        chk(first_req == STARTUP, "R2", "first request cycle", first_req, STARTUP);
        while (!init_done) @(negedge clk);
        chk(ras_falls == INIT_N, "R3", "refreshes before ready", ras_falls, INIT_N);
        // R8: spacing of periodic requests
        t0 = cyc;
        while (cyc < t0 + 3 * REFI + 20) @(negedge clk);
        chk(gap == REFI, "R8", "request spacing", gap, REFI);
        chk(ras_falls == INIT_N + 3, "R8", "periodic refresh count", ras_falls, INIT_N + 3);
        // R9: hold the grant over five credits, then release just after one
        hold = 1'b1;
        t0 = m_ticks;
        while (m_ticks < t0 + 5) @(negedge clk);
        chk(rf_req == 1'b1 && rf_own == 1'b0, "R7", "request held without grant",
            int'({rf_req, rf_own}), 2);
        ras_falls = 0;
        hold = 1'b0;
        repeat (60) @(negedge clk);
        chk(ras_falls == PMAX, "R9", "backlog refreshes issued", ras_falls, PMAX);
        chk(rf_req == 1'b0, "R9", "idle after backlog", int'(rf_req), 0);
        chk(we_n == 1'b1, "R5", "we_n after backlog", int'(we_n), 1);
        done_run = 1'b1;
        report();
    end
endmodule